// File: doc/BRIEF.md
# Multilevel Clamped-Leg Switching Sequencer

This block drives one leg of an n-level neutral-point-clamped converter. The leg works as a selector with one pole and n throws, which joins the AC terminal to one of n DC-link points. A controller upstream computes one duty ratio per DC-link point and raises a one-cycle start pulse at every switching-period boundary. On that pulse the sequencer captures the ratios and turns each one into a dwell time in clock cycles. It then visits the DC-link points in ascending order, from point 1 up to point n, and holds each point for its own dwell time.

For the point currently selected, the block drives the leg's n−1 independent transistor controls as a thermometer code. It also drives the complement of that code for the devices that take inverted drive. Each dwell is the floor of the ratio times the period length. The rounding remainder is added to one point, so the dwells fill the period exactly. A point whose dwell is zero is skipped and never appears on the outputs. Dead time and gate drive are handled outside this block.

Top module: `npc_leg_seq`

## Requirements
- R1: Selecting DC-link point k (k = 1..LEVELS) drives `sw_o` with its lowest k−1 bits at 1 and every other bit at 0. Bit 0 is the control of the first transistor pair. Point 1 is therefore all zeros and point LEVELS is all ones.
- R2: `swn_o` is always the bitwise complement of `sw_o`.
- R3: While `rst_ni` is low, the outputs show point 1 (`sw_o` all zeros, `swn_o` all ones). They stay at point 1 after reset until the first start pulse is sampled. Reset takes effect without waiting for a clock edge.
- R4: A start pulse sampled at a rising edge captures `duty_i`. From the next cycle on, the leg steps through points in ascending order and never returns to a lower point until the next start.
- R5: The duty field for point k sits in bits [(k−1)·DUTY_W +: DUTY_W]. Its value is a fraction of the full scale 2^(DUTY_W−1), and the fields are expected to sum to that full scale. Point k is held for floor(field·PERIOD_CYC / 2^(DUTY_W−1)) cycles.
- R6: PERIOD_CYC minus the sum of those floors is added to the highest-numbered point whose duty field is nonzero. If every field is zero, point 1 receives the whole period. The dwells therefore total PERIOD_CYC cycles.
- R7: A point whose dwell is zero is skipped and is not shown for even one cycle.
- R8: Changes on `duty_i` while no start is sampled do not affect the sequence in progress.
- R9: When the last dwell ends and no new start has arrived, the outputs hold the final point's code until the next start.
- R10: A start sampled in the middle of a sequence abandons the rest of it. The new sequence begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse marking the start of a switching period |
| duty_i | input | LEVELS*DUTY_W | Duty ratios, one field per DC-link point, point 1 in the lowest field |
| sw_o | output | LEVELS-1 | Thermometer-coded transistor controls |
| swn_o | output | LEVELS-1 | Complement of `sw_o` for the inversely driven devices |

## Verification
The outputs are registered, so the first point of a period appears one cycle after the edge that samples the start pulse. Each point then holds for exactly its dwell count, and cycle i of the period shows the point whose cumulative dwell window contains i. Inputs are driven on the falling edge and outputs are compared on the falling edge of each of those cycles. The expected point comes from dwells that the bench computes itself from the floor-and-remainder rule. After the final dwell the hold value is checked on every later cycle, and the effect of reset is checked on the first falling edge after it is asserted.

// File: rtl/npcseq_pkg.sv
package npcseq_pkg;

    // Sequencer phase: idle after reset, stepping through points, or parked on the final point.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_phase_e;

endpackage

// File: rtl/npcseq_dwell.sv
// Converts a set of duty fields into dwell counts that fill one switching period exactly.
module npcseq_dwell #(
    parameter int LEVELS     = 5,
    parameter int DUTY_W     = 11,
    parameter int PERIOD_CYC = 20000,
    parameter int CNT_W      = 15,
    parameter int IDX_W      = 3
) (
    input  logic [LEVELS*DUTY_W-1:0]       duty_i,
    output logic [LEVELS-1:0][CNT_W-1:0]   dwell_o
);
    localparam int PROD_W = DUTY_W + CNT_W;
    localparam int SUM_W  = CNT_W + $clog2(LEVELS) + 1;
    localparam int FRAC   = DUTY_W - 1;

    logic [LEVELS-1:0][CNT_W-1:0] raw;
    logic [IDX_W-1:0]             last_nz;
    logic [SUM_W-1:0]             sum;
    logic [SUM_W-1:0]             rem;

    // One scaling product per point.
    for (genvar k = 0; k < LEVELS; k++) begin : g_scale
        logic [PROD_W-1:0] prod;
        assign prod   = PROD_W'(duty_i[k*DUTY_W +: DUTY_W]) * PROD_W'(PERIOD_CYC);
        assign raw[k] = CNT_W'(prod >> FRAC);
    end

    always_comb begin
        sum     = '0;
        last_nz = '0;
        for (int k = 0; k < LEVELS; k++) begin
            sum = sum + SUM_W'(raw[k]);
            if (duty_i[k*DUTY_W +: DUTY_W] != '0) begin
                last_nz = IDX_W'(k);
            end
        end
        rem              = SUM_W'(PERIOD_CYC) - sum;
        dwell_o          = raw;
        dwell_o[last_nz] = raw[last_nz] + CNT_W'(rem);
    end

endmodule

// File: rtl/npcseq_pick.sv
// Finds the lowest point at or above a starting index whose dwell is nonzero.
module npcseq_pick #(
    parameter int LEVELS = 5,
    parameter int CNT_W  = 15,
    parameter int IDX_W  = 3
) (
    input  logic [LEVELS-1:0][CNT_W-1:0] dwell_i,
    input  logic [IDX_W:0]               from_i,
    output logic [IDX_W-1:0]             idx_o,
    output logic                         found_o
);
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int k = LEVELS - 1; k >= 0; k--) begin
            if (((IDX_W + 1)'(k) >= from_i) && (dwell_i[k] != '0)) begin
                idx_o   = IDX_W'(k);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/npc_leg_seq.sv
module npc_leg_seq
    import npcseq_pkg::*;
#(
    parameter int LEVELS     = 5,
    parameter int DUTY_W     = 11,
    parameter int PERIOD_CYC = 20000
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic [LEVELS*DUTY_W-1:0] duty_i,
    output logic [LEVELS-2:0]        sw_o,
    output logic [LEVELS-2:0]        swn_o
);
    localparam int CNT_W = $clog2(PERIOD_CYC + 1);
    localparam int IDX_W = $clog2(LEVELS);
    localparam int SW_W  = LEVELS - 1;

    typedef struct packed {
        seq_phase_e                   phase;
        logic [IDX_W-1:0]             idx;
        logic [CNT_W-1:0]             rem;
        logic [LEVELS-1:0][CNT_W-1:0] dw;
        logic [SW_W-1:0]              sw;
        logic [SW_W-1:0]              swn;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [LEVELS-1:0][CNT_W-1:0] new_dw;
    logic [IDX_W-1:0]             first_idx, next_idx;
    logic                         first_found, next_found;
    logic [IDX_W:0]               next_from;

    npcseq_dwell #(
        .LEVELS(LEVELS), .DUTY_W(DUTY_W), .PERIOD_CYC(PERIOD_CYC),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_dwell (
        .duty_i (duty_i),
        .dwell_o(new_dw)
    );

    npcseq_pick #(.LEVELS(LEVELS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_first (
        .dwell_i(new_dw),
        .from_i ('0),
        .idx_o  (first_idx),
        .found_o(first_found)
    );

    assign next_from = (IDX_W + 1)'(st_q.idx) + (IDX_W + 1)'(1);

    npcseq_pick #(.LEVELS(LEVELS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_next (
        .dwell_i(st_q.dw),
        .from_i (next_from),
        .idx_o  (next_idx),
        .found_o(next_found)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.dw = new_dw;
            if (first_found) begin
                st_d.phase = SEQ_RUN;
                st_d.idx   = first_idx;
                st_d.rem   = new_dw[first_idx] - CNT_W'(1);
            end else begin
                st_d.phase = SEQ_HOLD;
                st_d.idx   = '0;
                st_d.rem   = '0;
            end
        end else if (st_q.phase == SEQ_RUN) begin
            if (st_q.rem != '0) begin
                st_d.rem = st_q.rem - CNT_W'(1);
            end else if (next_found) begin
                st_d.idx = next_idx;
                st_d.rem = st_q.dw[next_idx] - CNT_W'(1);
            end else begin
                st_d.phase = SEQ_HOLD;
            end
        end
        // Thermometer code: control j is on when the selected point lies above it.
        for (int j = 0; j < SW_W; j++) begin
            st_d.sw[j] = (IDX_W'(j) < st_d.idx);
        end
        st_d.swn = ~st_d.sw;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.swn <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_o  = st_q.sw;
    assign swn_o = st_q.swn;

endmodule

// File: rtl/npc_leg_seq_chk.sv
module npc_leg_seq_chk #(
    parameter int LEVELS = 5,
    parameter int DUTY_W = 11
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     start_i,
    input logic [LEVELS*DUTY_W-1:0] duty_i,
    input logic [LEVELS-2:0]        sw_o,
    input logic [LEVELS-2:0]        swn_o
);
    AST_SWN_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        swn_o == ~sw_o); // R2

    AST_THERMO_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sw_o + (LEVELS - 1)'(1)) & sw_o) == '0); // R1

    AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ($countones(sw_o) >= $countones($past(sw_o)))); // R4

    AST_SKIP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && (duty_i[DUTY_W-1:0] == '0) && (duty_i != '0)) |=> (sw_o != '0)); // R7

    AST_RESET_DC1: assert property (@(posedge clk_i)
        !rst_ni |=> (sw_o == '0)); // R3

endmodule

bind npc_leg_seq npc_leg_seq_chk #(.LEVELS(LEVELS), .DUTY_W(DUTY_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .duty_i (duty_i),
    .sw_o   (sw_o),
    .swn_o  (swn_o)
);

// File: tb/sim_npc_leg_seq.sv
module sim_npc_leg_seq;
    localparam int L  = 4;
    localparam int DW = 5;
    localparam int P  = 12;
    localparam int FS = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [L*DW-1:0] duty;
    logic [L-2:0]  sw, swn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    npc_leg_seq #(.LEVELS(L), .DUTY_W(DW), .PERIOD_CYC(P)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .duty_i(duty), .sw_o(sw), .swn_o(swn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [L*DW-1:0] pk(input int a, input int b, input int c, input int d);
        return {DW'(d), DW'(c), DW'(b), DW'(a)};
    endfunction

    function automatic logic [L-2:0] thermo(input int idx);
        return (L-1)'((1 << idx) - 1);
    endfunction

    // Expected point index (0 = first point) in cycle i after the sampled start.
    function automatic int exp_idx(input logic [L*DW-1:0] dv, input int i);
        int raw[L];
        int sum = 0;
        int last = 0;
        int acc = 0;
        int lastnz = 0;
        for (int k = 0; k < L; k++) begin
            raw[k] = int'(dv[k*DW +: DW]) * P / FS;
            sum += raw[k];
            if (dv[k*DW +: DW] != '0) last = k;
        end
        raw[last] += P - sum;
        for (int k = 0; k < L; k++) begin
            if (raw[k] > 0) begin
                lastnz = k;
                if (i >= acc && i < acc + raw[k]) return k;
                acc += raw[k];
            end
        end
        return lastnz;
    endfunction

    task automatic run_period(input logic [L*DW-1:0] dv, input int ncyc, input string tag);
        int ei;
        duty  = dv;
        start = 1'b1;
        @(posedge clk);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (i == 0) begin
                start = 1'b0;
                duty  = ~dv;   // R8: changes mid-sequence must be ignored
            end
            ei = exp_idx(dv, i);
            chk(sw == thermo(ei), tag, int'(sw), int'(thermo(ei)));
            chk(swn == ~thermo(ei), "R2", int'(swn), int'(~thermo(ei)));
        end
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4: watchdog expired, got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        duty  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sw == '0, "R3", int'(sw), 0);
        chk(swn == '1, "R3", int'(swn), 7);
        rst_n = 1'b1;
        duty  = pk(0, 0, 0, 16);
        repeat (4) @(negedge clk);
        chk(sw == '0, "R3", int'(sw), 0);   // no start yet: stays on point 1

        // R1: whole period on the top point, then on the bottom point
        run_period(pk(0, 0, 0, 16), P, "R1");
        run_period(pk(16, 0, 0, 0), P, "R1");

        // Exhaustive sweep of every split of full scale over four points
        for (int a = 0; a <= FS; a++) begin
            for (int b = 0; b <= FS - a; b++) begin
                for (int c = 0; c <= FS - a - b; c++) begin
                    run_period(pk(a, b, c, FS - a - b - c), P, "R4/R5/R6/R7/R8");
                end
            end
        end

        // R9: hold the final point after the period runs out
        run_period(pk(0, 8, 8, 0), P, "R9");
        for (int i = 0; i < 5; i++) begin
            duty = pk(i, 16 - i, 0, 0);
            @(negedge clk);
            chk(sw == thermo(2), "R9", int'(sw), int'(thermo(2)));
        end

        // R10: restart in the middle of a sequence
        run_period(pk(4, 4, 4, 4), 5, "R10");
        run_period(pk(16, 0, 0, 0), P, "R10");

        // R3: reset in the middle of a sequence
        run_period(pk(4, 4, 4, 4), 8, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        chk(sw == '0, "R3", int'(sw), 0);
        chk(swn == '1, "R3", int'(swn), 7);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sw == '0, "R3", int'(sw), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule